// File: doc/BRIEF.md
# Pilot-Interleaving Transmit Frame Assembler

This block builds one transmit frame at a time out of a queue of data symbols. It waits until the queue's fill level reaches a programmable threshold. It then sends out a fixed-length preamble, a fixed-length training section and a data section. The data section is cut into subframes. In each subframe, blocks of pilot symbols read from an on-chip lookup table are spread among the data symbols drawn from the queue.

The number of pilot blocks per subframe is a runtime setting. Changing it moves the pilot overhead between 6.25% and 50% without changing the hardware. Each output symbol carries a type tag and a last-of-frame flag, so later stages (mapping, spreading, shaping) know what they are handling. Data symbols are taken with a valid/ready handshake. When the queue runs empty during a data slot, the frame pauses and no filler symbols are inserted.

Top module: `pilot_frame_builder`

## Requirements
- R1: While idle, the block starts a frame only when `fifo_level >= start_thresh`. Below that level it emits nothing and takes no data.
- R2: A frame is exactly 2304 output symbols: 128 preamble symbols (tag 0, `out_sym` = position 0..127), then 128 training symbols (tag 1, `out_sym` = position 0..127), then a 2048-symbol data section.
- R3: The data section is 8 subframes of 256 symbols. Each subframe is split into λp segments, and each segment begins with a 16-symbol pilot block (tag 2) followed by data symbols (tag 3).
- R4: Each subframe carries 16·λp pilot symbols and 256−16·λp data symbols, so a frame carries 128·λp pilots and 2048−128·λp data symbols.
- R5: Every segment except the last holds floor((256−16·λp)/λp) data symbols. The last segment of the subframe also takes the remainder. For λp=6 this gives five segments of 26 and one of 30.
- R6: Pilot symbol k (k = 0..15) of every pilot block has the value (37·k + 11) mod 256.
- R7: A data symbol is taken only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only during data slots. Data symbols leave on `out_sym` in arrival order, one cycle after they are taken.
- R8: If `in_valid` is low during a data slot, `out_valid` stays low and the frame resumes when data arrives. No padding symbol is ever emitted.
- R9: λp is sampled when a frame starts and held to its end, so later changes to `pilot_reps` do not affect that frame. Legal values are 1, 2, 4, 6 and 8. Any other value is treated as 1.
- R10: `out_last` is high on the final data symbol of the frame and on no other output symbol.
- R11: After reset, `out_valid` and `in_ready` are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | 12 | Current fill level of the data symbol queue |
| start_thresh | input | 12 | Fill level at which a frame may start |
| pilot_reps | input | 4 | Requested pilot blocks per subframe (λp) |
| in_data | input | 8 | Data symbol at the head of the queue |
| in_valid | input | 1 | Queue offers a symbol |
| in_ready | output | 1 | Block takes a symbol this cycle (data slots only) |
| out_valid | output | 1 | Output symbol present |
| out_tag | output | 2 | Symbol type: 0 preamble, 1 training, 2 pilot, 3 data |
| out_sym | output | 8 | Position index, pilot value or data symbol |
| out_last | output | 1 | Final symbol of the frame |

## Verification
The assertions check five things on every cycle:
- a handshake always yields a tagged data output carrying the same symbol one cycle later;
- a starved data slot produces no output;
- the last flag appears only on data;
- the idle state is left only once the threshold is met;
- the sampled λp holds for the whole frame.

Only the bench's scenarios can show frame-level properties. These are the section lengths, the pilot and data counts for each λp, the uneven split at λp=6, and the pilot values. They also include the fallback for an illegal λp, the indifference to a λp change mid-frame, and the exact pause point when the queue runs dry.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum logic [1:0] {
    TAG_PRE = 2'd0,
    TAG_TRN = 2'd1,
    TAG_PIL = 2'd2,
    TAG_DAT = 2'd3
  } sym_tag_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_TRN,
    ST_PIL,
    ST_DAT
  } asm_state_e;

  // Legal repetition counts: 1, or an even value up to the maximum.
  function automatic logic rep_is_legal(input int rep, input int max_rep);
    return (rep == 1) || ((rep >= 2) && (rep <= max_rep) && (rep % 2 == 0));
  endfunction

endpackage

// File: rtl/pfb_pilot_rom.sv
module pfb_pilot_rom #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  parameter int MUL    = 37,
  parameter int ADD    = 11,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Table contents are computed, one entry per pilot position.
  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = WIDTH'((k * MUL + ADD) % (1 << WIDTH));
    end
  end

  // Synchronous read so the table maps onto block RAM.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/pfb_seg_plan.sv
module pfb_seg_plan #(
  parameter int SUBFR_LEN = 256,
  parameter int PBLK_LEN  = 16,
  parameter int MAX_REP   = 8,
  parameter int REP_W     = 4,
  parameter int CNT_W     = 9
) (
  input  logic [REP_W-1:0] rep_req,
  output logic [REP_W-1:0] rep_eff,
  output logic [CNT_W-1:0] seg_base,
  output logic [CNT_W-1:0] seg_last
);

  int rep_i;
  int data_n;
  int base_n;
  int rem_n;

  always_comb begin
    rep_i = pfb_pkg::rep_is_legal(int'(rep_req), MAX_REP) ? int'(rep_req) : 1;
    data_n = SUBFR_LEN - PBLK_LEN * rep_i;
    base_n = data_n / rep_i;
    rem_n  = data_n - base_n * rep_i;
    rep_eff  = REP_W'(rep_i);
    seg_base = CNT_W'(base_n);
    seg_last = CNT_W'(base_n + rem_n);
  end

endmodule

// File: rtl/pilot_frame_builder.sv
module pilot_frame_builder #(
  parameter int SYM_W     = 8,
  parameter int LVL_W     = 12,
  parameter int REP_W     = 4,
  parameter int PRE_LEN   = 128,
  parameter int TRN_LEN   = 128,
  parameter int SUBFR_LEN = 256,
  parameter int NUM_SUBFR = 8,
  parameter int PBLK_LEN  = 16,
  parameter int MAX_REP   = 8,
  parameter int PIL_MUL   = 37,
  parameter int PIL_ADD   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] start_thresh,
  input  logic [REP_W-1:0] pilot_reps,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             out_valid,
  output logic [1:0]       out_tag,
  output logic [SYM_W-1:0] out_sym,
  output logic             out_last
);
  import pfb_pkg::*;

  localparam int MAXLEN = (SUBFR_LEN > PRE_LEN) ?
                          ((SUBFR_LEN > TRN_LEN) ? SUBFR_LEN : TRN_LEN) :
                          ((PRE_LEN > TRN_LEN) ? PRE_LEN : TRN_LEN);
  localparam int CNT_W  = $clog2(MAXLEN + 1);
  localparam int SUB_W  = (NUM_SUBFR > 1) ? $clog2(NUM_SUBFR) : 1;
  localparam int PA_W   = (PBLK_LEN > 1) ? $clog2(PBLK_LEN) : 1;

  localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] TRN_END = CNT_W'(TRN_LEN - 1);
  localparam logic [CNT_W-1:0] PIL_END = CNT_W'(PBLK_LEN - 1);
  localparam logic [SUB_W-1:0] SUB_END = SUB_W'(NUM_SUBFR - 1);

  asm_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REP_W-1:0] seg_q;
  logic [SUB_W-1:0] sub_q;
  logic [REP_W-1:0] rep_q;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] lastlen_q;

  logic [REP_W-1:0] plan_rep;
  logic [CNT_W-1:0] plan_base;
  logic [CNT_W-1:0] plan_last;

  logic             vld_q;
  logic [1:0]       tag_q;
  logic [SYM_W-1:0] sym_q;
  logic             last_q;
  logic [SYM_W-1:0] pil_sym;

  pfb_seg_plan #(
    .SUBFR_LEN (SUBFR_LEN),
    .PBLK_LEN  (PBLK_LEN),
    .MAX_REP   (MAX_REP),
    .REP_W     (REP_W),
    .CNT_W     (CNT_W)
  ) u_plan (
    .rep_req  (pilot_reps),
    .rep_eff  (plan_rep),
    .seg_base (plan_base),
    .seg_last (plan_last)
  );

  pfb_pilot_rom #(
    .DEPTH (PBLK_LEN),
    .WIDTH (SYM_W),
    .MUL   (PIL_MUL),
    .ADD   (PIL_ADD)
  ) u_rom (
    .clk     (clk),
    .rd_en   (state_q == ST_PIL),
    .rd_addr (cnt_q[PA_W-1:0]),
    .rd_data (pil_sym)
  );

  logic             seg_is_last;
  logic [CNT_W-1:0] seg_end;
  logic             start_ok;

  always_comb begin
    seg_is_last = (seg_q == rep_q - REP_W'(1));
    seg_end     = (seg_is_last ? lastlen_q : base_q) - CNT_W'(1);
    start_ok    = (fifo_level >= start_thresh);
  end

  assign in_ready = (state_q == ST_DAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      seg_q     <= '0;
      sub_q     <= '0;
      rep_q     <= REP_W'(1);
      base_q    <= '0;
      lastlen_q <= '0;
      vld_q     <= 1'b0;
      tag_q     <= TAG_PRE;
      sym_q     <= '0;
      last_q    <= 1'b0;
    end else begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q   <= ST_PRE;
            cnt_q     <= '0;
            seg_q     <= '0;
            sub_q     <= '0;
            rep_q     <= plan_rep;
            base_q    <= plan_base;
            lastlen_q <= plan_last;
          end
        end
        ST_PRE: begin
          vld_q <= 1'b1;
          tag_q <= TAG_PRE;
          sym_q <= SYM_W'(cnt_q);
          if (cnt_q == PRE_END) begin
            state_q <= ST_TRN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_TRN: begin
          vld_q <= 1'b1;
          tag_q <= TAG_TRN;
          sym_q <= SYM_W'(cnt_q);
          if (cnt_q == TRN_END) begin
            state_q <= ST_PIL;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_PIL: begin
          vld_q <= 1'b1;
          tag_q <= TAG_PIL;
          if (cnt_q == PIL_END) begin
            state_q <= ST_DAT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_DAT: begin
          if (in_valid) begin
            vld_q <= 1'b1;
            tag_q <= TAG_DAT;
            sym_q <= in_data;
            if (cnt_q == seg_end) begin
              cnt_q <= '0;
              if (seg_is_last) begin
                seg_q <= '0;
                if (sub_q == SUB_END) begin
                  state_q <= ST_IDLE;
                  sub_q   <= '0;
                  last_q  <= 1'b1;
                end else begin
                  state_q <= ST_PIL;
                  sub_q   <= sub_q + SUB_W'(1);
                end
              end else begin
                state_q <= ST_PIL;
                seg_q   <= seg_q + REP_W'(1);
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = vld_q;
  assign out_tag   = tag_q;
  assign out_last  = last_q;
  assign out_sym   = (tag_q == TAG_PIL) ? pil_sym : sym_q;

  // R7: every handshake yields a data-tagged output of that symbol next cycle
  p_hs_to_data_r7: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=>
      (out_valid && out_tag == TAG_DAT && out_sym == $past(in_data)));

  // R8: a starved data slot produces no output symbol
  p_no_pad_r8: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !out_valid);

  // R10: the frame end flag only rides on a data symbol
  p_last_on_data_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (out_tag == TAG_DAT));

  // R1: idle is not left while the fill level is below threshold
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !(fifo_level >= start_thresh)) |=>
      (state_q == ST_IDLE && !out_valid));

  // R9: the sampled pilot count holds while a frame is in progress
  p_rep_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> (state_q == ST_IDLE || $stable(rep_q)));

endmodule

// File: tb/pilot_frame_builder_tb.sv
module pilot_frame_builder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_LEN  = 2304;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] fifo_level = '0;
  logic [11:0] start_thresh = 12'd40;
  logic [3:0]  pilot_reps = 4'd1;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [1:0]  out_tag;
  logic [7:0]  out_sym;
  logic        out_last;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  fifo_q[$];
  logic [10:0] cap[$];
  int          lasts = 0;
  bit          fire_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pilot_frame_builder u_dut (
    .clk          (clk),
    .rst          (rst),
    .fifo_level   (fifo_level),
    .start_thresh (start_thresh),
    .pilot_reps   (pilot_reps),
    .in_data      (in_data),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_tag      (out_tag),
    .out_sym      (out_sym),
    .out_last     (out_last)
  );

  // Queue model: pop what was taken at the last edge, then offer the head.
  always @(negedge clk) begin
    if (fire_prev) void'(fifo_q.pop_front());
    in_valid   = (fifo_q.size() != 0);
    in_data    = in_valid ? fifo_q[0] : 8'h00;
    fifo_level = 12'(fifo_q.size());
    fire_prev  = in_valid && in_ready;
  end

  // Output monitor: {last, tag, sym}
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      cap.push_back({out_last, out_tag, out_sym});
      if (out_last) lasts++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int n, input logic [7:0] seed);
    return 8'((n * 13 + int'(seed)) % 256);
  endfunction

  task automatic push_n(input int first, input int n, input logic [7:0] seed);
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) fifo_q.push_back(gen(first + i, seed));
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b0, "R11", "in_ready after reset", int'(in_ready), 0);
  endtask

  // One full frame scenario; eff is the λp the frame must use.
  task automatic run_frame(input logic [3:0] rep_in, input int eff,
                           input bit change, input logic [3:0] rep_mid,
                           input bit dry, input logic [7:0] seed,
                           input string name);
    int thr;
    int dtot;
    int dseg;
    int n;
    int mism;
    int first_bad;
    int pil_cnt;
    int dat_cnt;
    int last_cnt;
    int wd;
    logic [10:0] exp_q[$];
    thr  = dry ? 8 : 40;
    dtot = 8 * (256 - 16 * eff);
    dseg = (256 - 16 * eff) / eff;
    @(posedge clk); #1;
    cap.delete();
    lasts = 0;
    start_thresh = 12'(thr);
    pilot_reps   = rep_in;
    push_n(0, thr - 1, seed);
    repeat (60) @(posedge clk);
    #1;
    check(cap.size() == 0, "R1", {name, " no start below threshold"}, cap.size(), 0);
    check(fifo_q.size() == thr - 1, "R1", {name, " no data taken while idle"},
          fifo_q.size(), thr - 1);
    push_n(thr - 1, 1, seed);
    repeat (100) @(posedge clk);
    #1;
    check(fifo_q.size() == thr, "R7", {name, " nothing taken in preamble"},
          fifo_q.size(), thr);
    if (change) pilot_reps = rep_mid;
    if (dry) begin
      repeat (400) @(posedge clk);
      #1;
      check(cap.size() == 280, "R8", {name, " output pauses when queue empty"},
            cap.size(), 280);
    end
    push_n(thr, dtot - thr, seed);
    wd = 0;
    while (lasts == 0 && wd < 8000) begin
      @(posedge clk);
      wd++;
    end
    repeat (3) @(posedge clk);
    #1;
    // Expected stream built from the requirements.
    for (int i = 0; i < 128; i++) exp_q.push_back({1'b0, 2'd0, 8'(i)});
    for (int i = 0; i < 128; i++) exp_q.push_back({1'b0, 2'd1, 8'(i)});
    n = 0;
    for (int s = 0; s < 8; s++) begin
      for (int g = 0; g < eff; g++) begin
        int len;
        for (int k = 0; k < 16; k++)
          exp_q.push_back({1'b0, 2'd2, 8'((37 * k + 11) % 256)});
        len = (g == eff - 1) ? (256 - 16 * eff) - dseg * (eff - 1) : dseg;
        for (int d = 0; d < len; d++) begin
          exp_q.push_back({(s == 7 && g == eff - 1 && d == len - 1), 2'd3, gen(n, seed)});
          n++;
        end
      end
    end
    check(cap.size() == FRAME_LEN, "R2", {name, " frame length"}, cap.size(), FRAME_LEN);
    pil_cnt = 0; dat_cnt = 0; last_cnt = 0;
    foreach (cap[i]) begin
      if (cap[i][9:8] == 2'd2) pil_cnt++;
      if (cap[i][9:8] == 2'd3) dat_cnt++;
      if (cap[i][10]) last_cnt++;
    end
    check(pil_cnt == 128 * eff, "R4", {name, " pilot count"}, pil_cnt, 128 * eff);
    check(dat_cnt == dtot, "R4", {name, " data count"}, dat_cnt, dtot);
    check(last_cnt == 1 && cap.size() > 0 && cap[cap.size()-1][10], "R10",
          {name, " single last flag on final symbol"}, last_cnt, 1);
    mism = 0; first_bad = -1;
    for (int i = 0; i < FRAME_LEN; i++) begin
      if (i >= cap.size() || cap[i] !== exp_q[i]) begin
        if (first_bad < 0) first_bad = i;
        mism++;
      end
    end
    if (first_bad >= 0 && first_bad < cap.size())
      check(1'b0, "R3 R5 R6", {name, " stream content at first bad index (value)"},
            int'(cap[first_bad]), int'(exp_q[first_bad]));
    else
      check(mism == 0, "R3 R5 R6", {name, " stream content mismatches"}, mism, 0);
    check(fifo_q.size() == 0, "R7", {name, " all data consumed once"}, fifo_q.size(), 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    test_reset();
    run_frame(4'd1, 1, 1'b0, 4'd0, 1'b0, 8'h11, "lp1");
    run_frame(4'd2, 2, 1'b0, 4'd0, 1'b0, 8'h22, "lp2");
    run_frame(4'd4, 4, 1'b0, 4'd0, 1'b0, 8'h33, "lp4");
    run_frame(4'd6, 6, 1'b0, 4'd0, 1'b0, 8'h44, "lp6 R5 uneven split");
    run_frame(4'd8, 8, 1'b0, 4'd0, 1'b0, 8'h55, "lp8");
    run_frame(4'd3, 1, 1'b0, 4'd0, 1'b0, 8'h66, "R9 illegal lp3 as 1");
    run_frame(4'd4, 4, 1'b1, 4'd2, 1'b0, 8'h77, "R9 lp change mid-frame");
    run_frame(4'd6, 6, 1'b0, 4'd0, 1'b1, 8'h88, "R8 dry queue");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule